// File: doc/BRIEF.md
# Frame End Position Backlog Register

This block captures the buffer address at which each encoded frame ends and offers it to the processor through a single 32-bit register. The register clears on read. The low 24 bits carry the end address. The top byte carries a status code that says whether the frame was reported on time, queued behind an earlier unread frame, or recorded after the backlog had overflowed.

Up to two unread positions are held, and the older one is always presented first. A level frame interrupt stays high while anything is unread. A separate overrun interrupt is raised when a frame completes while the backlog is already full. Only a synchronous reset clears the overrun interrupt.

Top module: `frame_end_backlog`

## Requirements
- R1: After a synchronous reset, `reg_rdata` reads zero and both `frame_irq` and `ovf_irq` are low.
- R2: `reg_rdata[23:0]` shows the end address of the oldest unread entry and `reg_rdata[31:24]` shows its status code. With no unread entry, all 32 bits read zero.
- R3: A frame completing with no unread entry is stored with status 0x09.
- R4: A frame completing with exactly one unread entry is stored behind it with status 0x0B. Reads return the older entry first, then the newer one.
- R5: A `reg_rd` pulse removes the presented entry, and the next entry (or zero) appears on the next cycle. A read with nothing unread changes nothing.
- R6: `frame_irq` is high exactly when at least one entry is unread.
- R7: A frame completing with two unread entries, and no read in that cycle, overwrites the newer entry with the new address and status 0x0E. The older entry is kept, and `ovf_irq` is raised.
- R8: Once high, `ovf_irq` stays high until a synchronous reset.
- R9: When a read and a frame completion fall in the same cycle, the read is applied first and the frame is classified on the remaining count. With two unread entries this gives status 0x0B and no overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_done | input | 1 | One-cycle pulse when a frame finishes encoding |
| frame_end_addr | input | 24 | End address of the finished frame, valid with `frame_done` |
| reg_rd | input | 1 | Processor read strobe for the register |
| reg_rdata | output | 32 | Register value: status byte and end address |
| frame_irq | output | 1 | Level interrupt, high while an entry is unread |
| ovf_irq | output | 1 | Sticky overrun interrupt |

## Verification
Embedded assertions check on every cycle the properties that can be stated locally:
- The frame interrupt implies a non-zero status byte.
- The overrun interrupt is sticky.
- A frame arriving into an empty backlog shows status 0x09 on the next cycle.
- Completion with two unread entries raises the overrun.
- Reading the last entry drops the interrupt.

Only the bench's scenarios can show the ordering of several entries through a sequence of reads. They also cover the overwrite of the newer entry on overflow, the same-cycle read-and-frame case, and the clearing of the overrun by reset.

// File: rtl/frame_end_backlog.sv
module frame_end_backlog #(
  parameter int AW = 24,
  parameter int SW = 8,
  parameter logic [SW-1:0] ST_OK   = 8'h09,
  parameter logic [SW-1:0] ST_LATE = 8'h0B,
  parameter logic [SW-1:0] ST_ERR  = 8'h0E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic [AW-1:0]     frame_end_addr,
  input  logic              reg_rd,
  output logic [SW+AW-1:0]  reg_rdata,
  output logic              frame_irq,
  output logic              ovf_irq
);
  localparam int EW = SW + AW;

  logic [EW-1:0] head, tail;
  logic [1:0]    cnt;
  logic          pop;
  logic [1:0]    cnt_left;

  assign pop      = reg_rd && (cnt != 2'd0);
  assign cnt_left = cnt - {1'b0, pop};

  always_ff @(posedge clk) begin
    if (rst) begin
      head    <= '0;
      tail    <= '0;
      cnt     <= 2'd0;
      ovf_irq <= 1'b0;
    end else begin
      if (pop) begin
        head <= tail;
        tail <= '0;
      end
      if (frame_done) begin
        case (cnt_left)
          2'd0:    head <= {ST_OK, frame_end_addr};
          2'd1:    tail <= {ST_LATE, frame_end_addr};
          default: begin
            tail    <= {ST_ERR, frame_end_addr};
            ovf_irq <= 1'b1;
          end
        endcase
      end
      cnt <= cnt_left + {1'b0, (frame_done && cnt_left != 2'd2)};
    end
  end

  assign reg_rdata = (cnt != 2'd0) ? head : '0;
  assign frame_irq = (cnt != 2'd0);

  assert_irq_has_status_R6: assert property (@(posedge clk) disable iff (rst)
    frame_irq |-> (reg_rdata[EW-1:AW] != '0));
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovf_irq |=> ovf_irq);
  assert_first_ok_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !frame_irq) |=> (frame_irq && reg_rdata[EW-1:AW] == ST_OK
                                     && reg_rdata[AW-1:0] == $past(frame_end_addr)));
  assert_full_overrun_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_done && !reg_rd && cnt == 2'd2) |=> ovf_irq);
  assert_read_once_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && cnt == 2'd1 && !frame_done) |=> (!frame_irq && reg_rdata == '0));
endmodule

// File: tb/tb_frame_end_backlog.sv
module tb_frame_end_backlog;
  logic        clk = 1'b0;
  logic        rst;
  logic        frame_done;
  logic [23:0] frame_end_addr;
  logic        reg_rd;
  logic [31:0] reg_rdata;
  logic        frame_irq;
  logic        ovf_irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  logic        exp_ovf = 1'b0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  frame_end_backlog dut (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_end_addr(frame_end_addr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .frame_irq(frame_irq), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected results into the scoreboard.
  task automatic cycle(input bit done, input logic [23:0] addr, input bit rd, input string tag);
    frame_done = done; frame_end_addr = addr; reg_rd = rd;
    if (rd) begin
      chk({tag, " R5 presented"}, reg_rdata, exp_q.size() ? exp_q[0] : 32'h0);
      if (exp_q.size()) void'(exp_q.pop_front());
    end
    if (done) begin
      if (exp_q.size() == 0)      exp_q.push_back({8'h09, addr});
      else if (exp_q.size() == 1) exp_q.push_back({8'h0B, addr});
      else begin exp_q[1] = {8'h0E, addr}; exp_ovf = 1'b1; end
    end
    @(negedge clk);
    frame_done = 1'b0; reg_rd = 1'b0;
    // Monitor: compares the outputs against the scoreboard head.
    chk({tag, " R2 data"}, reg_rdata, exp_q.size() ? exp_q[0] : 32'h0);
    chk({tag, " R6 irq"}, {31'b0, frame_irq}, {31'b0, exp_q.size() != 0});
    chk({tag, " R8 ovf"}, {31'b0, ovf_irq}, {31'b0, exp_ovf});
  endtask

  task automatic do_reset();
    rst = 1'b1; frame_done = 1'b0; reg_rd = 1'b0; frame_end_addr = '0;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    exp_q.delete(); exp_ovf = 1'b0;
    chk("R1 rdata", reg_rdata, 32'h0);
    chk("R1 irqs", {30'b0, frame_irq, ovf_irq}, 32'h0);
  endtask

  initial begin
    do_reset();
    cycle(1'b0, 24'h0, 1'b1, "R5 empty read");
    cycle(1'b1, 24'h001234, 1'b0, "R3 first");
    chk("R3 status", reg_rdata, 32'h09001234);
    cycle(1'b0, 24'h0, 1'b1, "R5 read once");
    chk("R5 cleared", reg_rdata, 32'h0);
    cycle(1'b1, 24'hABCDEF, 1'b0, "R4 a");
    cycle(1'b1, 24'h000100, 1'b0, "R4 b");
    cycle(1'b0, 24'h0, 1'b1, "R4 older first");
    chk("R4 newer late", reg_rdata, 32'h0B000100);
    cycle(1'b0, 24'h0, 1'b1, "R4 drain");
    cycle(1'b1, 24'h000010, 1'b0, "R7 a");
    cycle(1'b1, 24'h000020, 1'b0, "R7 b");
    cycle(1'b1, 24'h000030, 1'b0, "R7 overflow");
    chk("R7 ovf raised", {31'b0, ovf_irq}, 32'h1);
    cycle(1'b1, 24'h000040, 1'b0, "R7 overflow again");
    cycle(1'b0, 24'h0, 1'b1, "R7 older kept");
    chk("R7 err entry", reg_rdata, 32'h0E000040);
    cycle(1'b0, 24'h0, 1'b1, "R8 drain");
    chk("R8 still set", {31'b0, ovf_irq}, 32'h1);
    do_reset();
    cycle(1'b1, 24'h0000AA, 1'b0, "R9 a");
    cycle(1'b1, 24'h0000BB, 1'b0, "R9 b");
    cycle(1'b1, 24'h0000CC, 1'b1, "R9 read+frame full");
    chk("R9 no ovf", {31'b0, ovf_irq}, 32'h0);
    cycle(1'b0, 24'h0, 1'b1, "R9 next");
    chk("R9 late tag", reg_rdata, 32'h0B0000CC);
    cycle(1'b0, 24'h0, 1'b1, "R9 drain");
    cycle(1'b1, 24'h0000DD, 1'b1, "R9 read empty+frame");
    chk("R9 ok tag", reg_rdata, 32'h090000DD);
    for (int i = 0; i < 6; i++) cycle(1'b1, 24'(i * 3 + 1), i[0], "R2 mixed");
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule